// File: doc/BRIEF.md
# Register Block with Read and Write Access Strobes

A compact memory-mapped register block with two 8-bit registers behind a single-cycle CPU request port. A request carries a valid flag, a write flag, an address and write data. The block answers every request one cycle later with a registered acknowledge and registered read data.

The status register at address 0 is read-only to software. Its value comes straight from a hardware input. It raises a read strobe in the cycle in which that input is captured for the response. The control register at address 1 is read/write to software and resets to decimal 20. Its stored value drives a hardware output.

Each field drives single-cycle strobes to user logic in the request cycle. A read strobe fires only on software reads. A write strobe fires only on software writes. A generic access strobe fires on either kind of access. A modify strobe fires on writes, because no field here has a side effect on read. Reset is asynchronous and active low.

Top module: `regblk_strobe`

## Requirements
- R1: While rst_ni is low, every strobe output is low, rsp_ack_o is low, rsp_rdata_o is 0 and ctrl_value_o is 20 (0x14).
- R2: A read of address 0 raises stat_rd_stb_o and stat_acc_stb_o only in the request cycle. rsp_rdata_o in the next cycle equals the stat_in_i value that was present in that request cycle.
- R3: A write to address 0 is acknowledged with rsp_rdata_o = 0. It raises neither stat_rd_stb_o nor stat_acc_stb_o, and it changes no register.
- R4: A write to address 1 raises ctrl_wr_stb_o in the request cycle. During that cycle ctrl_value_o still shows the old value. From the next cycle on it shows the written data, with the strobe low unless another write follows.
- R5: A read of address 1 returns the current control value and leaves ctrl_wr_stb_o low.
- R6: ctrl_acc_stb_o is high in the request cycle of every read and every write to address 1, and low otherwise.
- R7: ctrl_mod_stb_o is high only in the request cycle of a write to address 1. Reads do not raise it.
- R8: A request to an unmapped address (2 or 3) is acknowledged with rsp_rdata_o = 0. It raises no strobe and changes no register.
- R9: rsp_ack_o is high for exactly one cycle, the cycle after each accepted request, and is low after a cycle with no request. A write returns rsp_rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Register address |
| req_wdata_i | input | 8 | Write data |
| rsp_rdata_o | output | 8 | Read data, one cycle after the request |
| rsp_ack_o | output | 1 | Acknowledge, one cycle after the request |
| stat_in_i | input | 8 | Hardware source of the status register |
| stat_rd_stb_o | output | 1 | Status field software-read strobe |
| stat_acc_stb_o | output | 1 | Status field any-access strobe |
| ctrl_value_o | output | 8 | Stored control value |
| ctrl_wr_stb_o | output | 1 | Control field software-write strobe |
| ctrl_acc_stb_o | output | 1 | Control field any-access strobe |
| ctrl_mod_stb_o | output | 1 | Control field modify strobe |

## Verification
Status reads are issued while stat_in_i changes every cycle. Each read returns only the value that was present while the read strobe was high, so an off-by-one in the capture cycle shows up as a neighbouring value. Writes to the control register come singly and back to back, and are mixed with reads of the same address. These patterns separate the write strobe from the access strobe and the modify strobe, and they catch a value that updates one cycle early or late. Writes to the read-only address and accesses to the unmapped addresses show whether decoding leaks a strobe or corrupts stored state.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned NUM_REGS = 2;
  localparam int unsigned STAT_IDX = 0;
  localparam int unsigned CTRL_IDX = 1;

  typedef struct packed {
    logic acc;
    logic rd;
    logic wr;
  } stb_t;
endpackage

// File: rtl/regblk_decode.sv
module regblk_decode #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_REGS = 2
) (
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [NUM_REGS-1:0] hit_o
);
  // strobes are forced low while reset is asserted
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit_o[i] = rst_ni & req_valid_i & (req_addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/regblk_field_hw.sv
module regblk_field_hw #(
  parameter int unsigned W = 8
) (
  input  logic         acc_i,
  input  logic         is_wr_i,
  input  logic [W-1:0] hw_in_i,
  output regblk_pkg::stb_t stb_o,
  output logic [W-1:0] rd_val_o
);
  // software cannot write: a write neither counts as an access nor reads
  assign stb_o.rd  = acc_i & ~is_wr_i;
  assign stb_o.acc = acc_i & ~is_wr_i;
  assign stb_o.wr  = 1'b0;
  assign rd_val_o  = hw_in_i;
endmodule

// File: rtl/regblk_field_sw.sv
module regblk_field_sw #(
  parameter int unsigned     W   = 8,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_i,
  input  logic         is_wr_i,
  input  logic [W-1:0] wdata_i,
  output regblk_pkg::stb_t stb_o,
  output logic         mod_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0] q;

  assign stb_o.acc = acc_i;
  assign stb_o.rd  = acc_i & ~is_wr_i;
  assign stb_o.wr  = acc_i & is_wr_i;
  assign mod_o     = acc_i & is_wr_i; // no read side effects

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= RST;
    else if (stb_o.wr) q <= wdata_i;
  end

  assign value_o = q;
endmodule

// File: rtl/regblk_strobe.sv
module regblk_strobe
  import regblk_pkg::*;
#(
  parameter int unsigned       DW       = DATA_W,
  parameter int unsigned       AW       = ADDR_W,
  parameter logic [DW-1:0]     CTRL_RST = DW'(20)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_ack_o,
  input  logic [DW-1:0] stat_in_i,
  output logic          stat_rd_stb_o,
  output logic          stat_acc_stb_o,
  output logic [DW-1:0] ctrl_value_o,
  output logic          ctrl_wr_stb_o,
  output logic          ctrl_acc_stb_o,
  output logic          ctrl_mod_stb_o
);
  logic [NUM_REGS-1:0] hit;
  stb_t                stat_stb, ctrl_stb;
  logic [DW-1:0]       stat_val, ctrl_val;
  logic [DW-1:0]       rd_mux;

  regblk_decode #(.ADDR_W(AW), .NUM_REGS(NUM_REGS)) u_dec (
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .hit_o       (hit)
  );

  regblk_field_hw #(.W(DW)) u_stat (
    .acc_i    (hit[STAT_IDX]),
    .is_wr_i  (req_write_i),
    .hw_in_i  (stat_in_i),
    .stb_o    (stat_stb),
    .rd_val_o (stat_val)
  );

  regblk_field_sw #(.W(DW), .RST(CTRL_RST)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (hit[CTRL_IDX]),
    .is_wr_i (req_write_i),
    .wdata_i (req_wdata_i),
    .stb_o   (ctrl_stb),
    .mod_o   (ctrl_mod_stb_o),
    .value_o (ctrl_val)
  );

  // read mux: sampled at the edge that ends the read strobe cycle
  always_comb begin
    rd_mux = '0;
    if (stat_stb.rd) rd_mux = stat_val;
    if (ctrl_stb.rd) rd_mux = ctrl_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_ack_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_ack_o   <= req_valid_i;
      rsp_rdata_o <= rd_mux;
    end
  end

  assign stat_rd_stb_o  = stat_stb.rd;
  assign stat_acc_stb_o = stat_stb.acc;
  assign ctrl_value_o   = ctrl_val;
  assign ctrl_wr_stb_o  = ctrl_stb.wr;
  assign ctrl_acc_stb_o = ctrl_stb.acc;
endmodule

// File: rtl/regblk_strobe_chk.sv
module regblk_strobe_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic [DW-1:0] req_wdata_i,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          rsp_ack_o,
  input logic [DW-1:0] stat_in_i,
  input logic          stat_rd_stb_o,
  input logic          stat_acc_stb_o,
  input logic [DW-1:0] ctrl_value_o,
  input logic          ctrl_wr_stb_o,
  input logic          ctrl_acc_stb_o,
  input logic          ctrl_mod_stb_o
);
  logic any_stb;
  assign any_stb = stat_rd_stb_o | stat_acc_stb_o | ctrl_wr_stb_o | ctrl_acc_stb_o | ctrl_mod_stb_o;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !any_stb && !rsp_ack_o); // R1
  AST_RD_STB_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_stb_o |-> req_valid_i && !req_write_i && req_addr_i == '0); // R2
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_stb_o |=> rsp_rdata_o == $past(stat_in_i)); // R2
  AST_RO_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && req_addr_i == '0 |-> !stat_rd_stb_o && !stat_acc_stb_o); // R3
  AST_WR_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_stb_o |=> ctrl_value_o == $past(req_wdata_i)); // R4
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_stb_o |=> $stable(ctrl_value_o)); // R4
  AST_MOD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_mod_stb_o |-> ctrl_wr_stb_o && ctrl_acc_stb_o); // R7
  AST_UNMAPPED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i > AW'(1) |-> !any_stb); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i > AW'(1) |=> rsp_rdata_o == '0); // R8
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_ack_o); // R9
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_ack_o); // R9
endmodule

bind regblk_strobe regblk_strobe_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_write_i    (req_write_i),
  .req_addr_i     (req_addr_i),
  .req_wdata_i    (req_wdata_i),
  .rsp_rdata_o    (rsp_rdata_o),
  .rsp_ack_o      (rsp_ack_o),
  .stat_in_i      (stat_in_i),
  .stat_rd_stb_o  (stat_rd_stb_o),
  .stat_acc_stb_o (stat_acc_stb_o),
  .ctrl_value_o   (ctrl_value_o),
  .ctrl_wr_stb_o  (ctrl_wr_stb_o),
  .ctrl_acc_stb_o (ctrl_acc_stb_o),
  .ctrl_mod_stb_o (ctrl_mod_stb_o)
);

// File: tb/tb_regblk_strobe.sv
`timescale 1ns/1ps
module tb_regblk_strobe;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_write_i = 1'b0;
  logic [1:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic [7:0] stat_in_i = '0;
  logic [7:0] rsp_rdata_o, ctrl_value_o;
  logic rsp_ack_o, stat_rd_stb_o, stat_acc_stb_o, ctrl_wr_stb_o, ctrl_acc_stb_o, ctrl_mod_stb_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ctrl_model = 8'd20;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  regblk_strobe dut (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor: every ack pops one expected response
  always @(negedge clk_i) begin
    if (rst_ni && rsp_ack_o) begin
      if (exp_q.size() == 0) begin
        chk("R9", "unexpected ack", 8'd1, 8'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "rdata", rsp_rdata_o, e);
      end
    end
  end

  // driver: one request per call, strobes checked inside the request cycle
  task automatic do_req(input bit wr, input logic [1:0] a, input logic [7:0] wd, input logic [7:0] stat, input string tag);
    logic [7:0] exp_rd;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = wd; stat_in_i = stat;
    #1;
    chk(tag, "stat_rd_stb", {7'd0, stat_rd_stb_o}, {7'd0, !wr && a == 2'd0});
    chk(tag, "stat_acc_stb", {7'd0, stat_acc_stb_o}, {7'd0, !wr && a == 2'd0});
    chk(tag, "ctrl_wr_stb", {7'd0, ctrl_wr_stb_o}, {7'd0, wr && a == 2'd1});
    chk(tag, "ctrl_acc_stb", {7'd0, ctrl_acc_stb_o}, {7'd0, a == 2'd1});
    chk(tag, "ctrl_mod_stb", {7'd0, ctrl_mod_stb_o}, {7'd0, wr && a == 2'd1});
    chk(tag, "ctrl_value old", ctrl_value_o, ctrl_model); // R4: old value during strobe
    exp_rd = 8'd0;
    if (!wr && a == 2'd0) exp_rd = stat;
    if (!wr && a == 2'd1) exp_rd = ctrl_model;
    exp_q.push_back(exp_rd);
    tag_q.push_back(tag);
    if (wr && a == 2'd1) ctrl_model = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      stat_in_i = stat_in_i + 8'd3;
      #1;
      chk("R4", "ctrl_value held", ctrl_value_o, ctrl_model);
    end
  endtask

  initial begin
    #100000;
    chk("R9", "watchdog expired", 8'd1, 8'd0);
    finish_run();
  end

  initial begin
    // R1: strobes stay low under reset even with a live request
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 2'd1; req_wdata_i = 8'hAA;
    repeat (3) @(negedge clk_i);
    chk("R1", "ctrl_wr_stb in reset", {7'd0, ctrl_wr_stb_o}, 8'd0);
    chk("R1", "ctrl_acc_stb in reset", {7'd0, ctrl_acc_stb_o}, 8'd0);
    chk("R1", "ctrl_mod_stb in reset", {7'd0, ctrl_mod_stb_o}, 8'd0);
    chk("R1", "ack in reset", {7'd0, rsp_ack_o}, 8'd0);
    chk("R1", "rdata in reset", rsp_rdata_o, 8'd0);
    chk("R1", "ctrl reset value", ctrl_value_o, 8'd20);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    idle(2);

    // R2: status read with hw input moving every cycle
    do_req(1'b0, 2'd0, 8'h00, 8'h10, "R2");
    do_req(1'b0, 2'd0, 8'h00, 8'hA5, "R2");
    idle(1);
    do_req(1'b0, 2'd0, 8'h00, 8'hFF, "R2");
    do_req(1'b0, 2'd0, 8'h00, 8'h00, "R2");
    idle(2); // R9: no ack without request

    // R5/R6: read control at reset value
    do_req(1'b0, 2'd1, 8'h00, 8'h33, "R5");
    idle(1);
    // R4/R6/R7: single write, then read back
    do_req(1'b1, 2'd1, 8'h55, 8'h34, "R4");
    idle(1);
    do_req(1'b0, 2'd1, 8'h00, 8'h35, "R6");
    // back-to-back writes then read
    do_req(1'b1, 2'd1, 8'h00, 8'h36, "R7");
    do_req(1'b1, 2'd1, 8'hFF, 8'h37, "R4");
    do_req(1'b0, 2'd1, 8'h00, 8'h38, "R5");
    idle(1);

    // R3: write to read-only register, then read it back
    do_req(1'b1, 2'd0, 8'h77, 8'h40, "R3");
    do_req(1'b0, 2'd0, 8'h00, 8'h41, "R3");
    idle(1);

    // R8: unmapped addresses
    do_req(1'b0, 2'd2, 8'h00, 8'h50, "R8");
    do_req(1'b1, 2'd3, 8'h12, 8'h51, "R8");
    do_req(1'b0, 2'd3, 8'h00, 8'h52, "R8");
    idle(3);

    chk("R9", "responses outstanding", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    finish_run();
  end
endmodule